// File: doc/BRIEF.md
# Masked BSSID Address Filter

This block decides, for each received frame, whether the frame's 48-bit BSSID belongs to the station and should be acknowledged. It holds a programmable own MAC address and a programmable per-bit mask. A frame is taken when every bit selected by the mask agrees between the frame's BSSID and the own MAC. Bits outside the mask are not compared. This lets one radio answer for several virtual BSSes whose addresses differ only in the unmasked bits. As a side effect, unrelated frames that agree on the masked bits are taken as well.

Software programs both 48-bit values through a narrow register write port. Each value is written as a 32-bit lower word and a 16-bit upper word, with address byte k in bits [8k+7:8k] of the 48-bit value. A helper accumulator derives the mask from the set of BSSIDs being served. It starts from all ones, narrows with each added BSSID, and is copied into the active mask by a commit strobe. The decision is registered and reported one cycle after the frame's valid strobe.

Top module: `bssid_filt`

## Requirements
- R1: After reset the own MAC is zero and the active mask is all ones, so only the all-zero BSSID is accepted; the helper accumulator reads all ones and acc_vld_o is low.
- R2: A frame is accepted exactly when ((bssid_i XOR own_mac) AND mask) is zero over all 48 bits.
- R3: acc_vld_o is high in exactly the cycle after a cycle with bssid_vld_i high; acc_o is low whenever acc_vld_o is low.
- R4: A write with wr_sel_i = 0 loads wr_data_i into own MAC bits [31:0] (address bytes 0 to 3); wr_sel_i = 1 loads own MAC bits [47:32] (bytes 4 and 5).
- R5: A write with wr_sel_i = 1 takes only wr_data_i[15:0]; wr_data_i[31:16] has no effect, and own MAC bits [31:0] keep their value.
- R6: wr_sel_i = 2 loads wr_data_i into mask bits [31:0]; wr_sel_i = 3 loads wr_data_i[15:0] into mask bits [47:32], and wr_data_i[31:16] has no effect.
- R7: hlp_clr_i reloads the helper accumulator with all ones on the next edge.
- R8: hlp_add_i without hlp_clr_i ANDs NOT(own_mac XOR hlp_bssid_i) into the accumulator; no accumulator bit ever goes from 0 to 1 without a clear.
- R9: hlp_commit_i copies the accumulator into the active mask; if a mask register write happens in the same cycle, the commit wins.
- R10: When hlp_clr_i and hlp_add_i are high in the same cycle, the clear wins and the accumulator becomes all ones.
- R11: With own MAC 1 and served BSSIDs 4 and 9, the committed mask is all ones except bits 0, 2 and 3. Frames 1, 4, 9 and 13 are then accepted and frame 6 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 MAC low, 1 MAC high, 2 mask low, 3 mask high |
| wr_data_i | input | 32 | Write data |
| bssid_vld_i | input | 1 | Frame BSSID valid strobe |
| bssid_i | input | 48 | Frame BSSID, byte k in bits [8k+7:8k] |
| acc_vld_o | output | 1 | Decision valid, one cycle after bssid_vld_i |
| acc_o | output | 1 | Frame accepted |
| hlp_clr_i | input | 1 | Reload helper accumulator with all ones |
| hlp_add_i | input | 1 | Fold hlp_bssid_i into the accumulator |
| hlp_bssid_i | input | 48 | Served BSSID for the helper |
| hlp_commit_i | input | 1 | Copy accumulator into the active mask |
| hlp_mask_o | output | 48 | Current helper accumulator |

## Verification
The hardest cases to reach from the ports are collisions between strobes that target the same state. Two are covered: a mask register write landing in the same cycle as a commit, and a clear landing in the same cycle as an add. The bench drives both strobes on one falling edge. It then reads the result back through hlp_mask_o, or through a sweep of single-bit frame flips that reveals every bit of the active mask. The accept rule is swept near-exhaustively: every single-bit deviation from the own MAC is tried under several masks, together with pseudo-random frames whose expected decision the bench computes from the rule.

// File: rtl/bssid_filt_pkg.sv
package bssid_filt_pkg;
  localparam int unsigned ADDR_W = 48;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    SEL_MAC_LO = 2'd0,
    SEL_MAC_HI = 2'd1,
    SEL_MSK_LO = 2'd2,
    SEL_MSK_HI = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/bssid_filt_regs.sv
module bssid_filt_regs
  import bssid_filt_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned WW = WORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [WW-1:0] wr_data_i,
  input  logic          commit_i,
  input  logic [AW-1:0] commit_mask_i,
  output logic [AW-1:0] mac_o,
  output logic [AW-1:0] mask_o
);
  localparam int unsigned HW = AW - WW;

  logic [AW-1:0] mac_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mac_q  <= '0;
      mask_q <= '1;
    end else begin
      if (wr_en_i) begin
        unique case (reg_sel_e'(wr_sel_i))
          SEL_MAC_LO: mac_q[WW-1:0]   <= wr_data_i;
          SEL_MAC_HI: mac_q[AW-1:WW]  <= wr_data_i[HW-1:0];
          SEL_MSK_LO: mask_q[WW-1:0]  <= wr_data_i;
          SEL_MSK_HI: mask_q[AW-1:WW] <= wr_data_i[HW-1:0];
          default: ;
        endcase
      end
      // commit overrides a same-cycle mask write
      if (commit_i) mask_q <= commit_mask_i;
    end
  end

  assign mac_o  = mac_q;
  assign mask_o = mask_q;

  assert_hi_keeps_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_MAC_HI) |=> $stable(mac_q[WW-1:0]));

  assert_commit_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (mask_q == $past(commit_mask_i)));

  assert_mask_still_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !(wr_en_i && wr_sel_i[1])) |=> $stable(mask_q));
endmodule

// File: rtl/bssid_filt_mask_acc.sv
module bssid_filt_mask_acc #(
  parameter int unsigned AW = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [AW-1:0] bssid_i,
  input  logic [AW-1:0] mac_i,
  output logic [AW-1:0] mask_o
);
  logic [AW-1:0] acc_q;
  logic [AW-1:0] common_bits;

  assign common_bits = ~(mac_i ^ bssid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '1;
    else if (clr_i) acc_q <= '1;
    else if (add_i) acc_q <= acc_q & common_bits;
  end

  assign mask_o = acc_q;

  assert_clr_ones_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (&acc_q));

  assert_no_bit_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((acc_q & ~$past(acc_q)) == '0));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !add_i) |=> $stable(acc_q));
endmodule

// File: rtl/bssid_filt_match.sv
module bssid_filt_match
  import bssid_filt_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [AW-1:0] bssid_i,
  input  logic [AW-1:0] mac_i,
  input  logic [AW-1:0] mask_i,
  output logic          vld_o,
  output logic          acc_o
);
  localparam int unsigned NL = AW / LANE_W;

  logic [NL-1:0] lane_ok;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LANE_W-1:0] f_m, o_m;
    assign f_m = bssid_i[l*LANE_W +: LANE_W] & mask_i[l*LANE_W +: LANE_W];
    assign o_m = mac_i[l*LANE_W +: LANE_W]   & mask_i[l*LANE_W +: LANE_W];
    assign lane_ok[l] = (f_m == o_m);
  end

  logic vld_q, acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      acc_q <= vld_i && (&lane_ok);
    end
  end

  assign vld_o = vld_q;
  assign acc_o = acc_q;

  assert_vld_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);

  assert_vld_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);

  assert_acc_qualified_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |-> vld_o);

  assert_accept_rule_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (((bssid_i ^ mac_i) & mask_i) == '0)) |=> acc_o);

  assert_reject_rule_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (((bssid_i ^ mac_i) & mask_i) != '0)) |=> !acc_o);
endmodule

// File: rtl/bssid_filt.sv
module bssid_filt
  import bssid_filt_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned WW = WORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [WW-1:0] wr_data_i,
  input  logic          bssid_vld_i,
  input  logic [AW-1:0] bssid_i,
  output logic          acc_vld_o,
  output logic          acc_o,
  input  logic          hlp_clr_i,
  input  logic          hlp_add_i,
  input  logic [AW-1:0] hlp_bssid_i,
  input  logic          hlp_commit_i,
  output logic [AW-1:0] hlp_mask_o
);
  logic [AW-1:0] mac, mask, acc_mask;

  bssid_filt_regs #(.AW(AW), .WW(WW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .commit_i(hlp_commit_i), .commit_mask_i(acc_mask),
    .mac_o(mac), .mask_o(mask)
  );

  bssid_filt_mask_acc #(.AW(AW)) u_acc (
    .clk_i, .rst_ni, .clr_i(hlp_clr_i), .add_i(hlp_add_i),
    .bssid_i(hlp_bssid_i), .mac_i(mac), .mask_o(acc_mask)
  );

  bssid_filt_match #(.AW(AW)) u_match (
    .clk_i, .rst_ni, .vld_i(bssid_vld_i), .bssid_i,
    .mac_i(mac), .mask_i(mask), .vld_o(acc_vld_o), .acc_o
  );

  assign hlp_mask_o = acc_mask;
endmodule

// File: tb/bssid_filt_bench.sv
`timescale 1ns/1ps
module bssid_filt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        bvld = 1'b0;
  logic [47:0] bssid = '0;
  logic        acc_vld, acc;
  logic        h_clr = 1'b0, h_add = 1'b0, h_commit = 1'b0;
  logic [47:0] h_bssid = '0;
  logic [47:0] h_mask;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [47:0] m_mac = '0;
  logic [47:0] m_mask = '1;
  logic [47:0] m_acc = '1;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  bssid_filt u_bssid_filt (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .bssid_vld_i(bvld), .bssid_i(bssid),
    .acc_vld_o(acc_vld), .acc_o(acc), .hlp_clr_i(h_clr), .hlp_add_i(h_add),
    .hlp_bssid_i(h_bssid), .hlp_commit_i(h_commit), .hlp_mask_o(h_mask)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: m_mac[31:0]   = d;
      2'd1: m_mac[47:32]  = d[15:0];
      2'd2: m_mask[31:0]  = d;
      default: m_mask[47:32] = d[15:0];
    endcase
  endtask

  task automatic frame(input string req, input logic [47:0] f);
    logic exp;
    exp = (((f ^ m_mac) & m_mask) == 48'd0);
    @(negedge clk);
    bvld = 1'b1; bssid = f;
    @(negedge clk);
    bvld = 1'b0;
    check({req, " vld"}, {47'd0, acc_vld}, 48'd1);
    check(req, {47'd0, acc}, {47'd0, exp});
  endtask

  task automatic sweep_bits(input string req);
    for (int b = 0; b < 48; b++) frame(req, m_mac ^ (48'd1 << b));
  endtask

  task automatic helper(input logic clr, input logic add, input logic [47:0] b);
    @(negedge clk);
    h_clr = clr; h_add = add; h_bssid = b;
    @(negedge clk);
    h_clr = 1'b0; h_add = 1'b0;
    if (clr) m_acc = '1;
    else if (add) m_acc = m_acc & ~(m_mac ^ b);
  endtask

  task automatic commit();
    @(negedge clk);
    h_commit = 1'b1;
    @(negedge clk);
    h_commit = 1'b0;
    m_mask = m_acc;
  endtask

  function automatic logic [63:0] next_rng(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 helper ones", h_mask, '1);
    check("R1 vld low", {47'd0, acc_vld}, 48'd0);
    frame("R1 zero frame", 48'd0);
    sweep_bits("R1 single bit");

    // R3: result valid only for one cycle, acc low when not valid
    @(negedge clk);
    check("R3 vld drops", {47'd0, acc_vld}, 48'd0);
    check("R3 acc low", {47'd0, acc}, 48'd0);

    // R4: byte placement of the own MAC
    wr(2'd0, 32'h4567_89AB);
    wr(2'd1, 32'h0000_0123);
    frame("R4 exact mac", 48'h0123_4567_89AB);
    sweep_bits("R4 full mask");

    // R5: upper data bits ignored, lower word kept
    wr(2'd1, 32'hFFFF_0123);
    frame("R5 mac intact", 48'h0123_4567_89AB);
    sweep_bits("R5 mac intact sweep");

    // R6: mask words
    wr(2'd2, 32'h0000_FFFF);
    wr(2'd3, 32'hABCD_00F0);
    sweep_bits("R6 mask bits");

    // R2: pseudo-random frames under several masks
    for (int k = 0; k < 3; k++) begin
      rng = next_rng(rng);
      wr(2'd2, rng[31:0]);
      wr(2'd3, {16'd0, rng[47:32]});
      for (int n = 0; n < 40; n++) begin
        rng = next_rng(rng);
        // half the frames close to the MAC to get accepts
        frame("R2 random", n[0] ? rng[47:0] : (m_mac ^ (rng[47:0] & ~m_mask)));
      end
    end

    // R7 / R8 / R11: worked example
    wr(2'd0, 32'd1);
    wr(2'd1, 32'd0);
    helper(1'b1, 1'b0, '0);
    check("R7 clear", h_mask, '1);
    helper(1'b0, 1'b1, 48'd4);
    check("R8 add first", h_mask, m_acc);
    helper(1'b0, 1'b1, 48'd9);
    check("R8 add second", h_mask, m_acc);
    check("R11 mask value", h_mask, ~48'hD);
    helper(1'b0, 1'b1, 48'd0);
    check("R8 no bit set", h_mask, ~48'hD);
    commit();
    check("R11 acc after commit", h_mask, ~48'hD);
    frame("R11 frame 1", 48'd1);
    frame("R11 frame 4", 48'd4);
    frame("R11 frame 9", 48'd9);
    frame("R11 frame 13", 48'd13);
    frame("R11 frame 6", 48'd6);
    check("R11 model 6 rejected", {47'd0, (((48'd6 ^ m_mac) & m_mask) == 0)}, 48'd0);

    // R10: clear beats add
    helper(1'b1, 1'b1, 48'h0F0F_0000_0000);
    check("R10 clear wins", h_mask, '1);

    // R9: commit beats a same-cycle mask write
    helper(1'b0, 1'b1, 48'h8000_0000_0001);
    @(negedge clk);
    h_commit = 1'b1; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'd0;
    @(negedge clk);
    h_commit = 1'b0; wr_en = 1'b0;
    m_mask = m_acc;
    sweep_bits("R9 commit wins");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule